// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous binary up-counter with a parameterised width. Its default width is 4 bits. It has an active-low asynchronous clear and an active-low synchronous parallel load. Two active-high enables allow counting. The first enable, `cnt_en`, acts only on the count register. The second enable, `carry_en`, also gates the terminal-count output `carry_out`.

`carry_out` is high when the count is at its maximum value and `carry_en` is high. It is combinational, so a change on `carry_en` reaches it within the same cycle.

Several stages can be chained to form a wider counter without any ripple clocking:
- All stages share the clock.
- All stages share one enable, which drives every `cnt_en` and the `carry_en` of the lowest stage.
- Each higher stage takes the `carry_out` of the stage below it on its `carry_en`.

The operating modes have a fixed priority, from highest to lowest: clear, load, count, hold.

Top module: `cbc_counter`

## Requirements
- R1: While `clr_n` is low, `q` is zero at once, with no clock edge needed. Clear overrides both load and count, including at a rising edge where `load_n` is low.
- R2: On a rising edge with `clr_n` high and `load_n` low, `q` takes the value of `din`, whatever the state of `cnt_en` and `carry_en`.
- R3: On a rising edge with `clr_n` and `load_n` high and both `cnt_en` and `carry_en` high, `q` increases by one.
- R4: On a rising edge with `clr_n` and `load_n` high and at least one of `cnt_en` or `carry_en` low, `q` keeps its value.
- R5: `carry_out` is high exactly when `carry_en` is high and `q` is all ones (15 at the default width). It follows `carry_en` within the same cycle and does not depend on `cnt_en`.
- R6: A counting edge at the maximum value wraps `q` to zero, and `carry_out` then falls.
- R7: Two 4-bit stages chained as described above step through the 8-bit sequence 0 to 255 and roll over from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| din | input | WIDTH | Parallel load value |
| cnt_en | input | 1 | Count enable that acts on the register only |
| carry_en | input | 1 | Count enable that also gates `carry_out` |
| q | output | WIDTH | Count value |
| carry_out | output | 1 | Terminal count: `carry_en` and all bits of `q` high |

## Verification
The bench drops `clr_n` in the middle of a cycle and checks that `q` is already zero before the next edge. A clear that waited for a clock edge would still show the old count at that point.

The bench then holds `load_n` low through an edge while `clr_n` is still low. A design with the priority inverted would load `din` on that edge.

At the maximum value, the bench toggles `carry_en` and `cnt_en` without a clock edge. A registered carry would lag by one cycle, and a carry gated by `cnt_en` would follow the wrong enable.

A two-stage chain is run through a full 8-bit rollover. This exposes an upper stage that counts on every edge, or one that misses the step from 255 to 0.

// File: rtl/cbc_pkg.sv
// Package: shared mode type for the cascadable counter.
// Assumes nothing beyond SystemVerilog 2017 enums.
package cbc_pkg;
    typedef enum logic [1:0] {
        MODE_CLEAR = 2'd0,
        MODE_LOAD  = 2'd1,
        MODE_COUNT = 2'd2,
        MODE_HOLD  = 2'd3
    } mode_e;
endpackage

// File: rtl/cbc_mode_decode.sv
// Module: resolves the control pins into one operating mode using the fixed
// priority clear > load > count > hold. Assumes active-low clear and load.
module cbc_mode_decode
    import cbc_pkg::*;
(
    input  logic  clr_n,
    input  logic  load_n,
    input  logic  cnt_en,
    input  logic  carry_en,
    output mode_e mode
);
    // Priority encoder over the control inputs.
    always_comb begin
        if (!clr_n)                   mode = MODE_CLEAR;
        else if (!load_n)             mode = MODE_LOAD;
        else if (cnt_en && carry_en)  mode = MODE_COUNT;
        else                          mode = MODE_HOLD;
    end
endmodule

// File: rtl/cbc_next_value.sv
// Module: computes the value the register takes at the next edge for the
// given mode. Assumes the increment wraps modulo 2**WIDTH.
module cbc_next_value
    import cbc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  mode_e             mode,
    input  logic [WIDTH-1:0]  cur,
    input  logic [WIDTH-1:0]  din,
    output logic [WIDTH-1:0]  nxt
);
    localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

    // Select between zero, the load value, the increment and the held value.
    always_comb begin
        unique case (mode)
            MODE_CLEAR: nxt = '0;
            MODE_LOAD:  nxt = din;
            MODE_COUNT: nxt = cur + STEP;
            default:    nxt = cur;
        endcase
    end
endmodule

// File: rtl/cbc_carry.sv
// Module: combinational terminal-count detector. It builds an AND chain over
// the count bits, seeded with the carry enable. Assumes no register on the path.
module cbc_carry #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             carry_en,
    output logic             carry_out
);
    logic [WIDTH:0] chain;

    assign chain[0] = carry_en;

    // One AND stage per count bit.
    for (genvar i = 0; i < WIDTH; i++) begin : g_and
        assign chain[i+1] = chain[i] & cur[i];
    end

    assign carry_out = chain[WIDTH];
endmodule

// File: rtl/cbc_counter.sv
// Module: cascadable presettable up-counter. The clear is asynchronous; load
// and count act on the rising clock edge. Assumes all stages of a chain share
// clk, and that each higher stage takes the carry of the stage below it on
// carry_en.
module cbc_counter
    import cbc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    input  logic             cnt_en,
    input  logic             carry_en,
    output logic [WIDTH-1:0] q,
    output logic             carry_out
);
    mode_e            mode;
    logic [WIDTH-1:0] cnt_r;
    logic [WIDTH-1:0] cnt_nxt;

    cbc_mode_decode u_dec (
        .clr_n    (clr_n),
        .load_n   (load_n),
        .cnt_en   (cnt_en),
        .carry_en (carry_en),
        .mode     (mode)
    );

    cbc_next_value #(.WIDTH(WIDTH)) u_nxt (
        .mode (mode),
        .cur  (cnt_r),
        .din  (din),
        .nxt  (cnt_nxt)
    );

    // Count register; the clear acts without waiting for a clock edge.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) cnt_r <= '0;
        else        cnt_r <= cnt_nxt;
    end

    cbc_carry #(.WIDTH(WIDTH)) u_carry (
        .cur       (cnt_r),
        .carry_en  (carry_en),
        .carry_out (carry_out)
    );

    assign q = cnt_r;
endmodule

// File: rtl/cbc_counter_chk.sv
// Module: property checker for cbc_counter, attached with bind. It observes
// ports only. Assumes the clear is sampled at rising edges.
module cbc_counter_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             clr_n,
    input logic             load_n,
    input logic [WIDTH-1:0] din,
    input logic             cnt_en,
    input logic             carry_en,
    input logic [WIDTH-1:0] q,
    input logic             carry_out
);
    localparam logic [WIDTH-1:0] STEP = WIDTH'(1);
    localparam logic [WIDTH-1:0] TOP  = '1;

    assert_clear_zero_R1: assert property (@(posedge clk)
        !clr_n |-> q == '0);

    assert_load_value_R2: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> q == $past(din));

    assert_count_step_R3: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && cnt_en && carry_en) |=> q == $past(q) + STEP);

    assert_hold_value_R4: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(cnt_en && carry_en)) |=> $stable(q));

    assert_carry_only_at_top_R5: assert property (@(posedge clk) disable iff (!clr_n)
        carry_out |-> (q == TOP && carry_en));

    assert_carry_when_top_R5: assert property (@(posedge clk) disable iff (!clr_n)
        (q == TOP && carry_en) |-> carry_out);

    assert_wrap_to_zero_R6: assert property (@(posedge clk) disable iff (!clr_n)
        (q == TOP && load_n && cnt_en && carry_en) |=> (q == '0 && !carry_out));
endmodule

bind cbc_counter cbc_counter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .clr_n     (clr_n),
    .load_n    (load_n),
    .din       (din),
    .cnt_en    (cnt_en),
    .carry_en  (carry_en),
    .q         (q),
    .carry_out (carry_out)
);

// File: tb/tb_cbc_counter.sv
module tb_cbc_counter;
    localparam int PERIOD   = 10;
    localparam int NVEC     = 12;
    localparam int WATCHDOG = 200000;

    logic       clk = 1'b0;
    logic       clr_n, load_n, cnt_en, carry_en;
    logic [3:0] din, q;
    logic       carry_out;

    // Chain of two stages for the 8-bit test.
    logic       c_clr_n, c_en;
    logic [3:0] lo_q, hi_q;
    logic       lo_co, hi_co;

    int n_chk  = 0;
    int n_fail = 0;

    always #(PERIOD/2) clk = ~clk;

    cbc_counter #(.WIDTH(4)) dut (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
        .cnt_en(cnt_en), .carry_en(carry_en), .q(q), .carry_out(carry_out)
    );

    cbc_counter #(.WIDTH(4)) u_lo (
        .clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .din(4'd0),
        .cnt_en(c_en), .carry_en(c_en), .q(lo_q), .carry_out(lo_co)
    );

    cbc_counter #(.WIDTH(4)) u_hi (
        .clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .din(4'd0),
        .cnt_en(c_en), .carry_en(lo_co), .q(hi_q), .carry_out(hi_co)
    );

    // Vector fields: load_n, cnt_en, carry_en, din[3:0], exp_q[3:0], exp_co.
    localparam logic [11:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 4'd5,  4'd5,  1'b0},  // R2 load, enables low
        {1'b0, 1'b1, 1'b1, 4'd9,  4'd9,  1'b0},  // R2 load beats count
        {1'b1, 1'b1, 1'b1, 4'd0,  4'd10, 1'b0},  // R3 count
        {1'b1, 1'b0, 1'b1, 4'd3,  4'd10, 1'b0},  // R4 hold, cnt_en low
        {1'b1, 1'b1, 1'b0, 4'd3,  4'd10, 1'b0},  // R4 hold, carry_en low
        {1'b0, 1'b1, 1'b1, 4'd14, 4'd14, 1'b0},  // R2 load 14
        {1'b1, 1'b1, 1'b1, 4'd0,  4'd15, 1'b1},  // R3/R5 reach top
        {1'b1, 1'b0, 1'b1, 4'd0,  4'd15, 1'b1},  // R4/R5 hold at top
        {1'b1, 1'b1, 1'b0, 4'd0,  4'd15, 1'b0},  // R5 carry gated off
        {1'b1, 1'b1, 1'b1, 4'd0,  4'd0,  1'b0},  // R6 wrap
        {1'b1, 1'b1, 1'b1, 4'd0,  4'd1,  1'b0},  // R3 count after wrap
        {1'b0, 1'b0, 1'b0, 4'd15, 4'd15, 1'b0}   // R2/R5 load top, carry_en low
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(PERIOD*WATCHDOG);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        clr_n = 1'b0; load_n = 1'b1; cnt_en = 1'b0; carry_en = 1'b0; din = '0;
        c_clr_n = 1'b0; c_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        // Reset state.
        check("R1 reset q", {4'd0, q}, 8'd0);
        check("R1 reset carry", {7'd0, carry_out}, 8'd0);
        clr_n = 1'b1;

        // Table walk: drive after the falling edge, sample 2 ns after the rising edge.
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            {load_n, cnt_en, carry_en, din} = VEC[i][11:5];
            @(posedge clk);
            #2;
            check($sformatf("R2-R6 vec %0d q", i), {4'd0, q}, {4'd0, VEC[i][4:1]});
            check($sformatf("R5 vec %0d carry", i), {7'd0, carry_out}, {7'd0, VEC[i][0]});
        end

        // R5: q is 15 and carry_en is low. Toggle the enables with no clock edge.
        @(negedge clk);
        load_n = 1'b1; cnt_en = 1'b0; carry_en = 1'b0;
        #1 carry_en = 1'b1;
        #1 check("R5 carry rises with carry_en", {7'd0, carry_out}, 8'd1);
        cnt_en = 1'b1; #0 cnt_en = 1'b0;
        #1 check("R5 carry ignores cnt_en", {7'd0, carry_out}, 8'd1);
        carry_en = 1'b0;
        #1 check("R5 carry falls with carry_en", {7'd0, carry_out}, 8'd0);

        // R1: clear in mid-cycle, with load also requested.
        @(posedge clk);
        #2;
        load_n = 1'b0; din = 4'd7; clr_n = 1'b0;
        #1 check("R1 mid-cycle clear", {4'd0, q}, 8'd0);
        @(posedge clk);
        #2 check("R1 clear beats load", {4'd0, q}, 8'd0);
        @(negedge clk);
        clr_n = 1'b1; load_n = 1'b1;
        @(posedge clk);
        #2 check("R4 idle after clear", {4'd0, q}, 8'd0);

        // R7: two-stage chain runs through a full 8-bit rollover.
        @(negedge clk);
        c_clr_n = 1'b1; c_en = 1'b1;
        for (int k = 1; k <= 260; k++) begin
            @(posedge clk);
            #2 check("R7 chained count", {hi_q, lo_q}, 8'(k % 256));
        end
        @(negedge clk);
        c_en = 1'b0;
        @(posedge clk);
        #2 check("R7 chain holds", {hi_q, lo_q}, 8'd4);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule